// File: doc/BRIEF.md
# Two-Channel Pin Event Interrupt Controller

This block turns activity on a small set of external pins into interrupt requests for a small 8-bit processor. Each pin goes through a synchroniser. A per-channel 2-bit sense field then decides what counts as an event: a low level, any change, a falling edge or a rising edge. In the edge modes, an event sets a sticky pending flag. In level mode, the request follows the synchronised pin directly and the flag stays at zero.

Requests are gated by an 8-bit enable (mask) register and by a global interrupt-enable input. The lowest-numbered active channel wins. Its number is presented with the request. When the processor acknowledges the request, only the reported channel's flag is cleared. Software can also clear flags by writing ones to an 8-bit flag register. The pin input is the value seen at the pad, so a pin that the chip drives itself still produces events.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, `mask_o`, `flag_o` and `irq_o` are all zero.
- R2: A write through `wr_mask_i` stores `wdata_i[1:0]` as the channel enables. Bits 7..2 of `mask_o` always read zero. Bit i enables channel i.
- R3: Channel i's sense field is `sense_i[2i+1:2i]`. With the value 11 (rising), a 0-to-1 pin change sets flag i. A 1-to-0 change does not. The flag is visible at the third rising clock edge after the pin change, and not at the second.
- R4: With the sense value 10 (falling), a 1-to-0 pin change sets the flag. A 0-to-1 change does not.
- R5: With the sense value 01 (any change), both pin transitions set the flag. A pin that does not change leaves it clear.
- R6: With the sense value 00 (low level), flag i reads zero at all times. The channel requests for as long as the synchronised pin is low, starting two clock edges after the pin falls.
- R7: `irq_o` is high only when `gie_i` is high and some channel has both its enable bit and its pending condition set. A disabled channel's flag still sets.
- R8: When both channels are pending and enabled, channel 0 wins. `irq_id_o` gives the winning channel number (0 or 1).
- R9: `ack_i`, sampled while `irq_o` is high, clears only the flag of the channel given by `irq_id_o`. `ack_i` has no effect while `irq_o` is low.
- R10: A write through `wr_flag_i` clears each flag whose `wdata_i` bit is one. Zero bits, and bits 7..2, leave the flags unchanged. Bits 7..2 of `flag_o` read zero.
- R11: If an edge is detected in the same cycle as a clear of the same flag, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2 | Pad values of the external pins |
| sense_i | input | 4 | Per-channel sense selection, 2 bits per channel |
| gie_i | input | 1 | Global interrupt enable |
| wr_mask_i | input | 1 | Write strobe for the enable register |
| wr_flag_i | input | 1 | Write strobe for the flag register (write one to clear) |
| wdata_i | input | 8 | Write data |
| ack_i | input | 1 | Processor acknowledge of the reported request |
| mask_o | output | 8 | Enable register readback |
| flag_o | output | 8 | Flag register readback |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 1 | Number of the winning channel |

## Verification
The hardest case to reach from the ports is a new edge detection landing in exactly the same clock as a clear of that flag. The detection only exists for a single cycle, two edges after the pin moves. The bench moves the pin at a falling clock edge and counts two rising edges. It then raises the flag-clear write so that the write lands on the third edge, together with the detection. The other hard cases are the acknowledge ordering with both channels pending, and an acknowledge issued while the request is masked off. Both are reached by setting the flags with gating closed and then opening the gating step by step.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int unsigned SENSE_W = 2;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        PIN_IDLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic smp_o,
   output logic prv_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pin_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   localparam int unsigned CHAIN = STAGES + 1;

   logic [CHAIN-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {CHAIN{PIN_IDLE}};
      else        chain_q <= {chain_q[CHAIN-2:0], pin_i};
   end

   assign smp_o = chain_q[STAGES-1];
   assign prv_o = chain_q[STAGES];
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
   import pin_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_i,
   input  logic               prv_i,
   input  logic [SENSE_W-1:0] sense_i,
   input  logic               clr_i,
   output logic               flag_o,
   output logic               pend_o
);
   sense_e mode;
   logic   lvl;
   logic   hit;
   logic   flag_q;

   assign mode = sense_e'(sense_i);
   assign lvl  = (mode == SENSE_LOW);

   always_comb begin
      unique case (mode)
         SENSE_ANY:  hit = smp_i ^ prv_i;
         SENSE_FALL: hit = prv_i & ~smp_i;
         SENSE_RISE: hit = smp_i & ~prv_i;
         default:    hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (lvl)   flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q & ~lvl;
   assign pend_o = lvl ? ~smp_i : flag_q;

   // R3 R4 R5 R11
   edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q);

   // R9 R10
   clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hit) |=> !flag_q);

   // R6
   level_keeps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl |=> !flag_q);
endmodule

// File: rtl/pin_irq_arb.sv
module pin_irq_arb #(
   parameter int unsigned NCH  = 2,
   parameter int unsigned ID_W = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  active_i,
   output logic            irq_o,
   output logic [ID_W-1:0] id_o,
   output logic [NCH-1:0]  grant_o
);
   always_comb begin
      id_o    = '0;
      grant_o = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (active_i[i]) begin
            id_o    = ID_W'(i);
            grant_o = NCH'(1) << i;
         end
      end
   end

   assign irq_o = |active_i;

   // R8
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R8
   winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> active_i[id_o]);
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
   import pin_irq_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned STAGES   = 2,
   parameter logic        PIN_IDLE = 1'b0,
   localparam int unsigned ID_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0]         pin_i,
   input  logic [SENSE_W*NCH-1:0] sense_i,
   input  logic                   gie_i,
   input  logic                   wr_mask_i,
   input  logic                   wr_flag_i,
   input  logic [REG_W-1:0]       wdata_i,
   input  logic                   ack_i,
   output logic [REG_W-1:0]       mask_o,
   output logic [REG_W-1:0]       flag_o,
   output logic                   irq_o,
   output logic [ID_W-1:0]        irq_id_o
);
   generate
      if (NCH < 1 || NCH > REG_W) begin : g_bad_nch
         $error("pin_irq_ctrl: NCH must lie in 1..REG_W");
      end
   endgenerate

   logic [NCH-1:0] mask_q;
   logic [NCH-1:0] flags;
   logic [NCH-1:0] pend;
   logic [NCH-1:0] active;
   logic [NCH-1:0] grant;
   logic [NCH-1:0] clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (wr_mask_i) mask_q <= wdata_i[NCH-1:0];
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic smp;
         logic prv;

         pin_irq_sync #(.STAGES(STAGES), .PIN_IDLE(PIN_IDLE)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_i[c]),
            .smp_o (smp),
            .prv_o (prv)
         );

         assign clr[c] = (wr_flag_i & wdata_i[c]) | (ack_i & grant[c]);

         pin_irq_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_i   (smp),
            .prv_i   (prv),
            .sense_i (sense_i[SENSE_W*c +: SENSE_W]),
            .clr_i   (clr[c]),
            .flag_o  (flags[c]),
            .pend_o  (pend[c])
         );
      end

      if (NCH < REG_W) begin : g_pad
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata_i[REG_W-1:NCH];
         assign mask_o = {{(REG_W-NCH){1'b0}}, mask_q};
         assign flag_o = {{(REG_W-NCH){1'b0}}, flags};
      end else begin : g_full
         assign mask_o = mask_q;
         assign flag_o = flags;
      end
   endgenerate

   assign active = pend & mask_q & {NCH{gie_i}};

   pin_irq_arb #(.NCH(NCH), .ID_W(ID_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .irq_o    (irq_o),
      .id_o     (irq_id_o),
      .grant_o  (grant)
   );

   // R7
   req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie_i);

   // R2
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask_i |=> (mask_q == $past(wdata_i[NCH-1:0])));
endmodule

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pin = 2'b00;
   logic [3:0] sense = 4'hF;
   logic       gie = 1'b0;
   logic       wr_mask = 1'b0;
   logic       wr_flag = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       ack = 1'b0;
   logic [7:0] mask_o;
   logic [7:0] flag_o;
   logic       irq_o;
   logic       irq_id_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pin_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_i(sense), .gie_i(gie),
      .wr_mask_i(wr_mask), .wr_flag_i(wr_flag), .wdata_i(wdata), .ack_i(ack),
      .mask_o(mask_o), .flag_o(flag_o), .irq_o(irq_o), .irq_id_o(irq_id_o)
   );

   // {sense[1:0], pin before, pin after, flag expected}
   localparam logic [4:0] VEC [8] = '{
      5'b11_01_1, 5'b11_10_0, 5'b10_10_1, 5'b10_01_0,
      5'b01_01_1, 5'b01_10_1, 5'b01_11_0, 5'b00_10_0
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_flags(input logic [7:0] d);
      wr_flag = 1'b1; wdata = d;
      edges(1);
      wr_flag = 1'b0; wdata = 8'h00;
   endtask

   task automatic wr_masks(input logic [7:0] d);
      wr_mask = 1'b1; wdata = d;
      edges(1);
      wr_mask = 1'b0; wdata = 8'h00;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      edges(1);
      ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      edges(3);
      // R1 reset state
      chk(mask_o == 8'h00, "R1 mask", mask_o, 0);
      chk(flag_o == 8'h00, "R1 flag", flag_o, 0);
      chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
      rst_n = 1'b1;
      edges(2);

      // R2 reserved mask bits
      wr_masks(8'hFF);
      chk(mask_o == 8'h03, "R2 mask", mask_o, 8'h03);
      gie = 1'b1;

      // table walk on channel 0: R3 R4 R5 R6
      for (int v = 0; v < 8; v++) begin
         logic [1:0] sm;
         logic       p0, p1, ef, ei;
         {sm, p0, p1, ef} = VEC[v];
         ei = (sm == 2'b00) ? ~p1 : ef;
         sense = {2'b11, sm};
         pin[0] = p0;
         edges(4);
         wr_flags(8'hFF);
         pin[0] = p1;
         edges(2);
         chk(flag_o[0] == 1'b0, $sformatf("R3 latency v%0d", v), flag_o, 0);
         edges(1);
         chk(flag_o[0] == ef, $sformatf("R3/R4/R5/R6 flag v%0d", v), flag_o[0], ef);
         chk(irq_o == ei, $sformatf("R6/R7 irq v%0d", v), irq_o, ei);
      end

      // R8 priority and R9 acknowledge ordering
      sense = 4'hF;
      pin = 2'b00;
      edges(4);
      wr_flags(8'hFF);
      pin = 2'b11;
      edges(3);
      chk(flag_o == 8'h03, "R8 both flags", flag_o, 3);
      chk(irq_o && irq_id_o == 1'b0, "R8 id0 wins", irq_id_o, 0);
      pulse_ack();
      chk(flag_o == 8'h02, "R9 ack clears ch0 only", flag_o, 2);
      chk(irq_o && irq_id_o == 1'b1, "R8 id1 next", irq_id_o, 1);
      pulse_ack();
      chk(flag_o == 8'h00, "R9 second ack", flag_o, 0);
      chk(irq_o == 1'b0, "R9 no request", irq_o, 0);

      // R7 gating; R9 ack ignored when no request
      sense = 4'hA;
      gie = 1'b0;
      pin[0] = 1'b0;
      edges(3);
      chk(flag_o == 8'h01, "R7 flag sets without gie", flag_o, 1);
      chk(irq_o == 1'b0, "R7 gie off", irq_o, 0);
      gie = 1'b1;
      wr_masks(8'h00);
      chk(irq_o == 1'b0, "R7 masked", irq_o, 0);
      pulse_ack();
      chk(flag_o == 8'h01, "R9 ack with irq low", flag_o, 1);
      wr_masks(8'h01);
      chk(irq_o == 1'b1, "R7 enabled", irq_o, 1);

      // R10 write one to clear
      pin[1] = 1'b0;
      edges(3);
      chk(flag_o == 8'h03, "R10 setup", flag_o, 3);
      wr_flags(8'h00);
      chk(flag_o == 8'h03, "R10 zero write", flag_o, 3);
      wr_flags(8'hFC);
      chk(flag_o == 8'h03, "R10 reserved bits", flag_o, 3);
      wr_flags(8'h02);
      chk(flag_o == 8'h01, "R10 clear ch1", flag_o, 1);
      wr_flags(8'h01);
      chk(flag_o == 8'h00, "R10 clear ch0", flag_o, 0);

      // R11 detection coinciding with clear
      sense = 4'hF;
      edges(2);
      pin[0] = 1'b1;
      edges(2);
      wr_flag = 1'b1; wdata = 8'h01;
      edges(1);
      wr_flag = 1'b0; wdata = 8'h00;
      chk(flag_o[0] == 1'b1, "R11 set wins", flag_o[0], 1);

      // R6 level flag stays zero with pin held low
      sense = 4'h0;
      pin = 2'b00;
      edges(4);
      chk(flag_o == 8'h00, "R6 level flags", flag_o, 0);

      done = 1'b1;
      finish_run();
   end
endmodule